// File: doc/BRIEF.md
# Capture/Compare Channel Bank with Shared Interrupt Vector

This block holds a small bank of timer capture/compare channels that watch a free-running count supplied from outside. Each channel is either a capture unit, which copies the count into its own register when a chosen edge appears on a chosen input, or a compare unit, which raises its event flag whenever the count equals the value held in that same register. Every channel has an event flag, an interrupt enable, a sticky overflow flag for captures that were not read in time, and an output bit that software drives straight onto a pin.

Channel 0 has an interrupt line of its own and clears its flag when the controller acknowledges it. The other channels share one interrupt line and one vector word. Reading the vector clears the flag of the channel it reports. The lowest-numbered pending channel is reported first.

Each channel tracks its capture register with a two-state machine. In SLOT_EMPTY there is no unread capture. A capture moves it to SLOT_FULL. In SLOT_FULL a further capture without a read in the same cycle keeps it in SLOT_FULL and sets the overflow flag. A read of the capture register with no capture in the same cycle returns it to SLOT_EMPTY. A capture and a read in the same cycle leave it in SLOT_FULL with no overflow.

Top module: `tmr_cc_bank`

## Requirements
- R1: After reset every event flag, overflow flag, output bit and interrupt enable is 0, all channels are in compare mode, `irq0` and `irq_vec` are 0, and `vec_code` is 0.
- R2: In capture mode (control bit 8 = 1) the channel copies `count` into its capture register at the clock edge that follows a selected edge on its selected input, and sets its event flag. Edge select is bits 10:9: bit 9 enables rising edges and bit 10 enables falling edges.
- R3: A capture while the channel holds an unread capture, with no capture-register read (`rd_ccr`) in the same cycle, sets the overflow flag (bit 1). A read never clears the overflow flag. Only a control write with bit 1 = 0 clears it. A read with no capture in the same cycle marks the slot as read.
- R4: In compare mode (bit 8 = 0) the event flag sets at each clock edge where `count` equals the channel's register, and compare events never set the overflow flag.
- R5: The event flag sets even when the enable (bit 4) is 0. `irq0` equals flag0 AND enable0 AND `gie`. `irq_vec` is `gie` AND the OR over channels 1 and up of flag AND enable.
- R6: `irq_ack0` clears the flag of channel 0. `vec_rd` has no effect on channel 0.
- R7: `vec_code` is twice the lowest channel index of 1 or more whose flag and enable are both set, or 0 when there is none. `vec_rd` clears only the flag of that channel.
- R8: A control write with bit 0 = 1 sets the flag, and this raises the interrupt line if the enable is set.
- R9: `out_pin[i]` follows the output bit (bit 2) last written to channel i.
- R10: Control read bit 3 shows the selected input. Select bits 13:12 choose it: 00 is input A, 01 is input B, 10 is constant 0, 11 is constant 1.
- R11: A hardware capture or compare event in the same cycle as a software clear, an acknowledge or a vector read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count | input | CW | Free-running timer count |
| in_a | input | NCH | External capture input A, one per channel |
| in_b | input | NCH | External capture input B, one per channel |
| gie | input | 1 | Global interrupt enable |
| ch_sel | input | CHW | Channel addressed by the bus strobes and reads |
| wr_ctl | input | 1 | Control word write strobe |
| wr_ccr | input | 1 | Capture/compare register write strobe |
| rd_ccr | input | 1 | Capture register read strobe (marks capture read) |
| wdata | input | CW | Write data |
| irq_ack0 | input | 1 | Acknowledge of the channel 0 interrupt |
| vec_rd | input | 1 | Shared vector read strobe |
| ctl_rdata | output | CW | Control/status word of the selected channel |
| ccr_rdata | output | CW | Capture/compare register of the selected channel |
| irq0 | output | 1 | Channel 0 interrupt request |
| irq_vec | output | 1 | Shared interrupt request for channels 1 and up |
| vec_code | output | VW | Vector word for the shared request |
| out_pin | output | NCH | Channel output pins |

## Verification
The assertions check several behaviours on every cycle. They confirm that the overflow flag is sticky against reads, that compare mode never raises overflow, and that a hardware event always leaves the flag set. They also check that both interrupt lines are held low without `gie`, that the shared line agrees with a non-zero vector, and that acknowledge and vector reads clear the intended flag. Only the bench scenarios can show the captured count values, the edge-select and input-select codes, the vector priority order, and the overflow sequence through read and re-capture.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_t;

    localparam int B_FLAG = 0;
    localparam int B_OV   = 1;
    localparam int B_OUT  = 2;
    localparam int B_IN   = 3;
    localparam int B_IE   = 4;
    localparam int B_MODE = 8;
    localparam int B_EDGE = 9;
    localparam int B_SEL  = 12;
    localparam int CTL_MIN_W = 14;
endpackage

// File: rtl/tmr_slot.sv
module tmr_slot
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_ev,
    input  logic rd,
    output logic ov_hit
);
    slot_t state_q;
    slot_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (cap_ev) state_d = SLOT_FULL;
            SLOT_FULL: begin
                if (cap_ev)  state_d = SLOT_FULL;
                else if (rd) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        ov_hit = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: ov_hit = 1'b0;
            SLOT_FULL:  ov_hit = cap_ev & ~rd;
            default:    ov_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          in_a,
    input  logic          in_b,
    input  logic          wr_ctl,
    input  logic          wr_ccr,
    input  logic          rd_ccr,
    input  logic [CW-1:0] wdata,
    input  logic          auto_clr,
    output logic          flag_o,
    output logic          ov_o,
    output logic          ie_o,
    output logic          capm_o,
    output logic          outv_o,
    output logic          event_o,
    output logic [CW-1:0] ccr_o,
    output logic [CW-1:0] ctl_o
);
    logic          flag_q, ov_q, outv_q, ie_q, capm_q, prev_q;
    logic [1:0]    edge_q, insel_q;
    logic [CW-1:0] ccr_q;
    logic          sel_in, rise, fall, cap_ev, cmp_ev, hw_ev, ov_hit;

    always_comb begin
        unique case (insel_q)
            2'b00:   sel_in = in_a;
            2'b01:   sel_in = in_b;
            2'b10:   sel_in = 1'b0;
            default: sel_in = 1'b1;
        endcase
    end

    assign rise   = sel_in & ~prev_q;
    assign fall   = ~sel_in & prev_q;
    assign cap_ev = capm_q & ((edge_q[0] & rise) | (edge_q[1] & fall));
    assign cmp_ev = ~capm_q & (count == ccr_q);
    assign hw_ev  = cap_ev | cmp_ev;

    tmr_slot u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_ev (cap_ev),
        .rd     (rd_ccr),
        .ov_hit (ov_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            ov_q    <= 1'b0;
            outv_q  <= 1'b0;
            ie_q    <= 1'b0;
            capm_q  <= 1'b0;
            edge_q  <= 2'b00;
            insel_q <= 2'b00;
            prev_q  <= 1'b0;
            ccr_q   <= '0;
        end else begin
            prev_q <= sel_in;
            if (wr_ctl) begin
                outv_q  <= wdata[B_OUT];
                ie_q    <= wdata[B_IE];
                capm_q  <= wdata[B_MODE];
                edge_q  <= wdata[B_EDGE+1:B_EDGE];
                insel_q <= wdata[B_SEL+1:B_SEL];
            end
            if (hw_ev)         flag_q <= 1'b1;
            else if (wr_ctl)   flag_q <= wdata[B_FLAG];
            else if (auto_clr) flag_q <= 1'b0;
            if (ov_hit)        ov_q <= 1'b1;
            else if (wr_ctl)   ov_q <= wdata[B_OV];
            if (cap_ev)        ccr_q <= count;
            else if (wr_ccr)   ccr_q <= wdata;
        end
    end

    always_comb begin
        ctl_o = '0;
        ctl_o[B_FLAG] = flag_q;
        ctl_o[B_OV]   = ov_q;
        ctl_o[B_OUT]  = outv_q;
        ctl_o[B_IN]   = sel_in;
        ctl_o[B_IE]   = ie_q;
        ctl_o[B_MODE] = capm_q;
        ctl_o[B_EDGE+1:B_EDGE] = edge_q;
        ctl_o[B_SEL+1:B_SEL]   = insel_q;
    end

    assign flag_o  = flag_q;
    assign ov_o    = ov_q;
    assign ie_o    = ie_q;
    assign capm_o  = capm_q;
    assign outv_o  = outv_q;
    assign event_o = hw_ev;
    assign ccr_o   = ccr_q;
endmodule

// File: rtl/tmr_vec.sv
module tmr_vec #(
    parameter int NCH = 3,
    parameter int VW  = 3
) (
    input  logic [NCH-1:0] pend,
    input  logic           vec_rd,
    output logic [VW-1:0]  code,
    output logic [NCH-1:0] clr
);
    always_comb begin
        code = '0;
        clr  = '0;
        for (int i = NCH - 1; i >= 1; i--) begin
            if (pend[i]) begin
                code = VW'(2 * i);
                clr  = '0;
                clr[i] = vec_rd;
            end
        end
    end
endmodule

// File: rtl/tmr_cc_bank.sv
module tmr_cc_bank
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int VW  = $clog2(NCH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  count,
    input  logic [NCH-1:0] in_a,
    input  logic [NCH-1:0] in_b,
    input  logic           gie,
    input  logic [CHW-1:0] ch_sel,
    input  logic           wr_ctl,
    input  logic           wr_ccr,
    input  logic           rd_ccr,
    input  logic [CW-1:0]  wdata,
    input  logic           irq_ack0,
    input  logic           vec_rd,
    output logic [CW-1:0]  ctl_rdata,
    output logic [CW-1:0]  ccr_rdata,
    output logic           irq0,
    output logic           irq_vec,
    output logic [VW-1:0]  vec_code,
    output logic [NCH-1:0] out_pin
);
    logic [NCH-1:0] flag_v, ov_v, ie_v, capm_v, ev_v, pend_v, vclr_v, aclr_v;
    logic [CW-1:0]  ccr_a [NCH];
    logic [CW-1:0]  ctl_a [NCH];

    initial begin
        if (CW < CTL_MIN_W) $error("CW too small for control word");
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = (ch_sel == CHW'(i));
        if (i == 0) begin : g_zero
            assign aclr_v[i] = irq_ack0;
            assign pend_v[i] = 1'b0;
        end else begin : g_shared
            assign aclr_v[i] = vclr_v[i];
            assign pend_v[i] = flag_v[i] & ie_v[i];
        end
        tmr_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .count    (count),
            .in_a     (in_a[i]),
            .in_b     (in_b[i]),
            .wr_ctl   (wr_ctl & hit),
            .wr_ccr   (wr_ccr & hit),
            .rd_ccr   (rd_ccr & hit),
            .wdata    (wdata),
            .auto_clr (aclr_v[i]),
            .flag_o   (flag_v[i]),
            .ov_o     (ov_v[i]),
            .ie_o     (ie_v[i]),
            .capm_o   (capm_v[i]),
            .outv_o   (out_pin[i]),
            .event_o  (ev_v[i]),
            .ccr_o    (ccr_a[i]),
            .ctl_o    (ctl_a[i])
        );
    end

    tmr_vec #(.NCH(NCH), .VW(VW)) u_vec (
        .pend   (pend_v),
        .vec_rd (vec_rd),
        .code   (vec_code),
        .clr    (vclr_v)
    );

    always_comb begin
        ctl_rdata = '0;
        ccr_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel == CHW'(i)) begin
                ctl_rdata = ctl_a[i];
                ccr_rdata = ccr_a[i];
            end
        end
    end

    assign irq0    = flag_v[0] & ie_v[0] & gie;
    assign irq_vec = gie & (|pend_v);
endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk #(
    parameter int NCH = 3,
    parameter int CHW = 2,
    parameter int VW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           gie,
    input logic           irq_ack0,
    input logic           vec_rd,
    input logic           wr_ctl,
    input logic [CHW-1:0] ch_sel,
    input logic           irq0,
    input logic           irq_vec,
    input logic [VW-1:0]  vec_code,
    input logic [NCH-1:0] flag,
    input logic [NCH-1:0] ov,
    input logic [NCH-1:0] ev,
    input logic [NCH-1:0] capm
);
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (!irq0 && !irq_vec)); // R5

    AST_VEC_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        gie |-> ((vec_code != '0) == irq_vec)); // R7

    AST_ACK0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack0 && !ev[0] && !(wr_ctl && ch_sel == '0)) |=> !flag[0]); // R6

    AST_VEC_SPARES_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !irq_ack0 && flag[0] && !(wr_ctl && ch_sel == '0)) |=> flag[0]); // R6

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ov[i] && !(wr_ctl && ch_sel == CHW'(i))) |=> ov[i]); // R3

        AST_CMP_NO_OV: assert property (@(posedge clk) disable iff (!rst_n)
            (!capm[i] && !ov[i] && !(wr_ctl && ch_sel == CHW'(i))) |=> !ov[i]); // R4

        AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flag[i]); // R11

        if (i > 0) begin : g_vec
            AST_VEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (vec_rd && vec_code == VW'(2 * i) && !ev[i] && !(wr_ctl && ch_sel == CHW'(i)))
                |=> !flag[i]); // R7
        end
    end
endmodule

bind tmr_cc_bank tmr_cc_chk #(.NCH(NCH), .CHW(CHW), .VW(VW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gie      (gie),
    .irq_ack0 (irq_ack0),
    .vec_rd   (vec_rd),
    .wr_ctl   (wr_ctl),
    .ch_sel   (ch_sel),
    .irq0     (irq0),
    .irq_vec  (irq_vec),
    .vec_code (vec_code),
    .flag     (flag_v),
    .ov       (ov_v),
    .ev       (ev_v),
    .capm     (capm_v)
);

// File: tb/sim_tmr_cc_bank.sv
module sim_tmr_cc_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int CW  = 16;
    localparam int CHW = 2;
    localparam int VW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [CW-1:0]  count = 16'hFFFF;
    logic [NCH-1:0] in_a = '0, in_b = '0;
    logic           gie = 1'b0;
    logic [CHW-1:0] ch_sel = '0;
    logic           wr_ctl = 1'b0, wr_ccr = 1'b0, rd_ccr = 1'b0;
    logic [CW-1:0]  wdata = '0;
    logic           irq_ack0 = 1'b0, vec_rd = 1'b0;
    logic [CW-1:0]  ctl_rdata, ccr_rdata;
    logic           irq0, irq_vec;
    logic [VW-1:0]  vec_code;
    logic [NCH-1:0] out_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_cc_bank #(.NCH(NCH), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .count(count), .in_a(in_a), .in_b(in_b),
        .gie(gie), .ch_sel(ch_sel), .wr_ctl(wr_ctl), .wr_ccr(wr_ccr),
        .rd_ccr(rd_ccr), .wdata(wdata), .irq_ack0(irq_ack0), .vec_rd(vec_rd),
        .ctl_rdata(ctl_rdata), .ccr_rdata(ccr_rdata), .irq0(irq0),
        .irq_vec(irq_vec), .vec_code(vec_code), .out_pin(out_pin)
    );

    function automatic logic [CW-1:0] mk(input bit fl, input bit ovf, input bit outv,
                                         input bit ie, input bit cap,
                                         input logic [1:0] edg, input logic [1:0] sel);
        logic [CW-1:0] w;
        w = '0;
        w[0] = fl; w[1] = ovf; w[2] = outv; w[4] = ie; w[8] = cap;
        w[10:9] = edg; w[13:12] = sel;
        return w;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wctl(input int ch, input logic [CW-1:0] w);
        ch_sel = CHW'(ch); wdata = w; wr_ctl = 1'b1;
        tick();
        wr_ctl = 1'b0;
    endtask

    task automatic wccr(input int ch, input logic [CW-1:0] w);
        ch_sel = CHW'(ch); wdata = w; wr_ccr = 1'b1;
        tick();
        wr_ccr = 1'b0;
    endtask

    task automatic rdccr(input int ch);
        ch_sel = CHW'(ch); rd_ccr = 1'b1;
        tick();
        rd_ccr = 1'b0;
    endtask

    task automatic look(input int ch);
        ch_sel = CHW'(ch);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] cfg1;
        bit unread [NCH];
        bit ovm [NCH];
        void'($urandom(32'd1234));

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        look(0);
        chk("R1 ctl0", 32'(ctl_rdata), 32'h0);
        look(2);
        chk("R1 ctl2", 32'(ctl_rdata), 32'h0);
        chk("R1 irq", {30'd0, irq0, irq_vec}, 32'h0);
        chk("R1 vec", 32'(vec_code), 32'h0);
        chk("R1 out", 32'(out_pin), 32'h0);

        gie = 1'b1;
        count = 16'h0100;

        // R2 capture on rising edge
        cfg1 = mk(0, 0, 0, 1, 1, 2'b01, 2'b00);
        wctl(1, cfg1);
        count = 16'h1234; in_a[1] = 1'b1;
        tick();
        look(1);
        chk("R2 ccr", 32'(ccr_rdata), 32'h1234);
        chk("R2 flag", 32'(ctl_rdata[0]), 32'h1);
        chk("R7 vec ch1", 32'(vec_code), 32'h2);
        count = 16'h5555; in_a[1] = 1'b0;
        tick();
        chk("R2 no fall capture", 32'(ccr_rdata), 32'h1234);
        chk("R3 no ov yet", 32'(ctl_rdata[1]), 32'h0);

        // R3 overflow sequence
        count = 16'h2222; in_a[1] = 1'b1;
        tick();
        chk("R3 ccr", 32'(ccr_rdata), 32'h2222);
        chk("R3 ov set", 32'(ctl_rdata[1]), 32'h1);
        rdccr(1);
        look(1);
        chk("R3 ov sticky on read", 32'(ctl_rdata[1]), 32'h1);
        in_a[1] = 1'b0;
        tick();
        wctl(1, mk(1, 0, 0, 1, 1, 2'b01, 2'b00));
        look(1);
        chk("R3 ov cleared", 32'(ctl_rdata[1]), 32'h0);
        count = 16'h3333; in_a[1] = 1'b1;
        tick();
        look(1);
        chk("R3 no ov after read", 32'(ctl_rdata[1]), 32'h0);
        in_a[1] = 1'b0;
        tick();
        count = 16'h4444; in_a[1] = 1'b1;
        tick();
        look(1);
        chk("R3 ov again", 32'(ctl_rdata[1]), 32'h1);
        rdccr(1);
        wctl(1, mk(1, 0, 0, 1, 1, 2'b01, 2'b00));
        in_a[1] = 1'b0;
        tick();

        // R8 and R7 software set and vector priority
        wctl(2, mk(1, 0, 0, 1, 1, 2'b00, 2'b00));
        chk("R8 irq_vec", 32'(irq_vec), 32'h1);
        chk("R7 lowest first", 32'(vec_code), 32'h2);
        vec_rd = 1'b1;
        tick();
        vec_rd = 1'b0;
        look(1);
        chk("R7 ch1 cleared", 32'(ctl_rdata[0]), 32'h0);
        look(2);
        chk("R7 ch2 kept", 32'(ctl_rdata[0]), 32'h1);
        chk("R7 vec ch2", 32'(vec_code), 32'h4);
        vec_rd = 1'b1;
        tick();
        vec_rd = 1'b0;
        chk("R7 vec empty", {28'd0, vec_code, irq_vec}, 32'h0);

        // R6 channel 0 acknowledge
        wctl(0, mk(1, 0, 0, 1, 0, 2'b00, 2'b00));
        chk("R8 irq0", 32'(irq0), 32'h1);
        vec_rd = 1'b1;
        tick();
        vec_rd = 1'b0;
        look(0);
        chk("R6 vec_rd ignored", 32'(ctl_rdata[0]), 32'h1);
        irq_ack0 = 1'b1;
        tick();
        irq_ack0 = 1'b0;
        look(0);
        chk("R6 ack clears", {30'd0, ctl_rdata[0], irq0}, 32'h0);

        // R5 enable and global gating
        wctl(0, mk(1, 0, 0, 0, 0, 2'b00, 2'b00));
        look(0);
        chk("R5 flag without ie", {30'd0, ctl_rdata[0], irq0}, 32'h2);
        wctl(0, mk(1, 0, 0, 1, 0, 2'b00, 2'b00));
        gie = 1'b0;
        #1;
        chk("R5 gie low", 32'(irq0), 32'h0);
        gie = 1'b1;
        #1;
        chk("R5 gie high", 32'(irq0), 32'h1);
        irq_ack0 = 1'b1;
        tick();
        irq_ack0 = 1'b0;

        // R4 compare
        wctl(2, mk(0, 0, 0, 1, 0, 2'b00, 2'b00));
        wccr(2, 16'h0777);
        count = 16'h0777;
        tick();
        look(2);
        chk("R4 compare flag", 32'(ctl_rdata[0]), 32'h1);
        chk("R4 vec", 32'(vec_code), 32'h4);
        tick(); tick();
        look(2);
        chk("R4 no ov", 32'(ctl_rdata[1]), 32'h0);
        count = 16'h0100;
        wctl(2, mk(0, 0, 0, 1, 0, 2'b00, 2'b00));
        tick();
        look(2);
        chk("R4 no match", 32'(ctl_rdata[0]), 32'h0);

        // R11 hardware event beats clears
        ch_sel = 2'd1; wdata = mk(0, 0, 0, 1, 1, 2'b01, 2'b00); wr_ctl = 1'b1;
        in_a[1] = 1'b1;
        tick();
        wr_ctl = 1'b0;
        look(1);
        chk("R11 beats sw clear", 32'(ctl_rdata[0]), 32'h1);
        in_a[1] = 1'b0;
        tick();
        chk("R11 pending", 32'(vec_code), 32'h2);
        in_a[1] = 1'b1; vec_rd = 1'b1;
        tick();
        vec_rd = 1'b0;
        look(1);
        chk("R11 beats vec_rd", 32'(ctl_rdata[0]), 32'h1);

        // R9 output bit
        wctl(1, mk(1, 0, 1, 1, 1, 2'b01, 2'b00));
        chk("R9 pin high", 32'(out_pin), 32'h2);
        wctl(1, mk(1, 0, 0, 1, 1, 2'b01, 2'b00));
        chk("R9 pin low", 32'(out_pin), 32'h0);

        // R10 input select
        in_a[0] = 1'b0; in_b[0] = 1'b1;
        wctl(0, mk(0, 0, 0, 0, 0, 2'b00, 2'b01));
        look(0);
        chk("R10 sel B", 32'(ctl_rdata[3]), 32'h1);
        wctl(0, mk(0, 0, 0, 0, 0, 2'b00, 2'b10));
        look(0);
        chk("R10 sel low", 32'(ctl_rdata[3]), 32'h0);
        wctl(0, mk(0, 0, 0, 0, 0, 2'b00, 2'b11));
        look(0);
        chk("R10 sel high", 32'(ctl_rdata[3]), 32'h1);
        in_a[0] = 1'b1;
        wctl(0, mk(0, 0, 0, 0, 0, 2'b00, 2'b00));
        look(0);
        chk("R10 sel A", 32'(ctl_rdata[3]), 32'h1);

        // R2 R3 random captures on both edges
        in_a[1] = 1'b0; in_a[2] = 1'b0;
        tick();
        for (int c = 1; c < NCH; c++) begin
            rdccr(c);
            wctl(c, mk(0, 0, 0, 0, 1, 2'b11, 2'b00));
            unread[c] = 1'b0;
            ovm[c] = 1'b0;
        end
        for (int n = 0; n < 60; n++) begin
            int ch;
            ch = 1 + int'($urandom % 2);
            if ($urandom % 2 == 0) begin
                rdccr(ch);
                unread[ch] = 1'b0;
            end
            if ($urandom % 5 == 0) begin
                wctl(ch, mk(0, 0, 0, 0, 1, 2'b11, 2'b00));
                ovm[ch] = 1'b0;
            end
            count = CW'($urandom) | 16'h0001;
            in_a[ch] = ~in_a[ch];
            tick();
            ovm[ch] = ovm[ch] | unread[ch];
            unread[ch] = 1'b1;
            look(ch);
            chk("R2 random ccr", 32'(ccr_rdata), 32'(count));
            chk("R3 random ov", 32'(ctl_rdata[1]), 32'(ovm[ch]));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule